// File: doc/BRIEF.md
# Receive payload output stage (serial / nibble)

This block sits after a receive framer and hands the recovered line bit stream to system-side equipment. The framer supplies one bit per clock with a valid strobe and a flag that marks the bit as overhead. A static mode input selects one of two presentations of that stream.

In serial mode, every valid bit appears on a single data pin, whether it is payload or overhead. An indicator runs alongside the data and is high for overhead bits. A gapped clock gives a second way to mark the bits: it pulses only for payload bits. Serial outputs are launched on the rising clock edge, so the receiver samples them on the falling edge. In nibble mode, overhead bits are dropped and payload bits are packed four at a time onto a 4-bit bus, with a one-period strobe for each completed group. Nibble outputs are launched on the falling edge, so the receiver samples them on the rising edge. The outputs of whichever mode is not selected are held at zero.

Top module: `rx_payload_out`

## Requirements
- R1: `nib_mode` low selects serial presentation and `nib_mode` high selects nibble presentation. The mode input is sampled on both clock edges.
- R2: In serial mode, each valid input bit (payload or overhead) appears on `ser_data`. It is launched on the first rising edge after capture and held until the next valid bit arrives.
- R3: In serial mode, `oh_ind` is launched together with each bit on `ser_data`. It is high exactly when that bit was flagged as overhead.
- R4: In serial mode, `gap_clk` is high during the high phase of the clock period in which a valid payload bit is on `ser_data`. It is low during periods that carry overhead bits or no valid bit, and it is always low while `clk` is low.
- R5: In nibble mode, overhead and invalid bits are skipped. Each group of four payload bits is presented on `nib_data`, with the first received bit in bit 3 and the last in bit 0.
- R6: In nibble mode, `nib_data` and `nib_stb` change on the falling edge. `nib_stb` is high for exactly one clock period per completed group, and `nib_data` holds until the next group completes.
- R7: The outputs of the inactive mode are zero. In nibble mode this covers `ser_data`, `oh_ind` and `gap_clk`. In serial mode it covers `nib_data` and `nib_stb`.
- R8: A change of mode discards any partly assembled group. The first group after returning to nibble mode contains four fresh payload bits.
- R9: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock; line bits arrive one per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| nib_mode | input | 1 | 0 = serial presentation, 1 = nibble presentation |
| in_bit | input | 1 | Line bit from the framer |
| in_valid | input | 1 | Qualifies `in_bit` this period |
| in_oh | input | 1 | `in_bit` is an overhead bit |
| ser_data | output | 1 | Serial line data (serial mode) |
| oh_ind | output | 1 | Overhead marker for `ser_data` |
| gap_clk | output | 1 | Clock gated to payload periods (serial mode) |
| nib_data | output | 4 | Assembled payload group (nibble mode) |
| nib_stb | output | 1 | One-period strobe per completed group |

## Verification
The stimulus for a period is driven 1 ns after a rising edge. The serial outputs take it up at the next rising edge. The nibble outputs take it up at the falling edge in the middle of the same period. Both results are therefore visible 1 ns after the following rising edge, and the bench compares every output there against a one-step arithmetic model of that stimulus. `gap_clk` is checked a second time at mid-low phase, where it must be zero. The sweeps cover every combination of bit, overhead flag and valid. They run long stretches in each mode and include mode flips that fall in the middle of a group.

// File: rtl/rx_payload_out.sv
module rx_payload_out #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nib_mode,
  input  logic             in_bit,
  input  logic             in_valid,
  input  logic             in_oh,
  output logic             ser_data,
  output logic             oh_ind,
  output logic             gap_clk,
  output logic [NIB_W-1:0] nib_data,
  output logic             nib_stb
);
  localparam int CW = (NIB_W > 2) ? $clog2(NIB_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(NIB_W - 1);

  logic             gap_en;
  logic [NIB_W-2:0] sh;
  logic [CW-1:0]    cnt;
  logic [NIB_W-1:0] nxt;
  logic             take;

  // serial path, launched on the rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_data <= 1'b0;
      oh_ind   <= 1'b0;
    end else if (nib_mode) begin
      ser_data <= 1'b0;
      oh_ind   <= 1'b0;
    end else if (in_valid) begin
      ser_data <= in_bit;
      oh_ind   <= in_oh;
    end
  end

  // gate enable moves only while clk is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gap_en <= 1'b0;
    else        gap_en <= !nib_mode && in_valid && !in_oh;
  end

  assign gap_clk = clk & gap_en;

  // nibble path, launched on the falling edge
  assign take = nib_mode && in_valid && !in_oh;
  assign nxt  = {sh, in_bit};

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= '0;
      nib_data <= '0;
      nib_stb  <= 1'b0;
    end else if (!nib_mode) begin
      sh       <= '0;
      cnt      <= '0;
      nib_data <= '0;
      nib_stb  <= 1'b0;
    end else begin
      nib_stb <= 1'b0;
      if (take) begin
        sh <= nxt[NIB_W-2:0];
        if (cnt == LAST) begin
          cnt      <= '0;
          nib_data <= nxt;
          nib_stb  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2
  ser_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nib_mode && in_valid) |=> (ser_data == $past(in_bit) && oh_ind == $past(in_oh)));

  // R7
  ser_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nib_mode) |-> (!ser_data && !oh_ind));

  // R7
  nib_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_mode |-> (nib_data == '0 && !nib_stb));

  // R4
  gap_payload_chk: assert property (@(negedge clk) disable iff (!rst_n)
    gap_clk |-> !oh_ind);

  // R6
  stb_single_chk: assert property (@(negedge clk) disable iff (!rst_n)
    nib_stb |=> !nib_stb);

  // R6
  stb_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !nib_stb && nib_mode |=> (nib_stb || $stable(nib_data) || !nib_mode));
endmodule

// File: tb/test_rx_payload_out.sv
module test_rx_payload_out;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nib_mode = 1'b0, in_bit = 1'b0, in_valid = 1'b0, in_oh = 1'b0;
  logic ser_data, oh_ind, gap_clk, nib_stb;
  logic [3:0] nib_data;

  int n_chk = 0, n_ok = 0;
  bit done = 0;

  logic e_ser = 0, e_oh = 0, e_gap = 0, e_stb = 0;
  logic [3:0] e_nib = 0, acc = 0;
  int cnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  rx_payload_out #(.NIB_W(4)) i_rx_payload_out (
    .clk(clk), .rst_n(rst_n), .nib_mode(nib_mode), .in_bit(in_bit),
    .in_valid(in_valid), .in_oh(in_oh), .ser_data(ser_data), .oh_ind(oh_ind),
    .gap_clk(gap_clk), .nib_data(nib_data), .nib_stb(nib_stb));

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act === exp) n_ok++;
    else $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
  endtask

  task automatic check_now();
    chk(nib_mode ? "R7 ser_data" : "R2 ser_data", {3'b0, ser_data}, {3'b0, e_ser});
    chk(nib_mode ? "R7 oh_ind" : "R3 oh_ind", {3'b0, oh_ind}, {3'b0, e_oh});
    chk("R4 gap_clk high phase", {3'b0, gap_clk}, {3'b0, e_gap});
    chk(nib_mode ? "R5 nib_data" : "R7 nib_data", nib_data, e_nib);
    chk("R6 nib_stb", {3'b0, nib_stb}, {3'b0, e_stb});
  endtask

  // R1: model of both presentations, picked by m
  task automatic step(input logic m, input logic b, input logic o, input logic v);
    @(posedge clk); #1;
    check_now();
    nib_mode = m; in_bit = b; in_oh = o; in_valid = v;
    if (m) begin e_ser = 0; e_oh = 0; end
    else if (v) begin e_ser = b; e_oh = o; end
    e_gap = !m && v && !o;
    if (!m) begin
      cnt = 0; acc = 0; e_nib = 0; e_stb = 0;   // R8 partial group dropped
    end else begin
      e_stb = 0;
      if (v && !o) begin
        acc = {acc[2:0], b};
        cnt++;
        if (cnt == 4) begin e_nib = acc; e_stb = 1; cnt = 0; end
      end
    end
    #2;
    chk("R4 gap_clk low phase", {3'b0, gap_clk}, 4'h0);
  endtask

  function automatic logic [15:0] nx(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_ok, n_chk);
      $finish;
    end
  end

  initial begin
    #5;
    chk("R9 ser_data", {3'b0, ser_data}, 4'h0);
    chk("R9 oh_ind", {3'b0, oh_ind}, 4'h0);
    chk("R9 gap_clk", {3'b0, gap_clk}, 4'h0);
    chk("R9 nib_data", nib_data, 4'h0);
    chk("R9 nib_stb", {3'b0, nib_stb}, 4'h0);
    @(posedge clk); #1; rst_n = 1'b1;

    // exhaustive combos of bit/overhead/valid in each mode
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 64; r++)
        for (int c = 0; c < 8; c++)
          step(m[0], c[0], c[1], c[2]);

    // known nibble sequence: 1,0,1,1 with overhead interleaved -> 4'hB
    step(1, 1, 0, 1); step(1, 0, 1, 1); step(1, 0, 0, 1); step(1, 1, 0, 0);
    step(1, 1, 0, 1); step(1, 0, 1, 1); step(1, 1, 0, 1);
    step(1, 0, 0, 0);
    chk("R5 known group", nib_data, 4'hB);

    // R8: flip to serial mid-group and back
    step(1, 1, 0, 1); step(1, 1, 0, 1); step(0, 0, 0, 1); step(1, 0, 0, 1);
    step(1, 0, 0, 1); step(1, 0, 0, 1); step(1, 1, 0, 1); step(1, 0, 0, 0);
    chk("R8 fresh group", nib_data, 4'h1);

    // pseudo-random runs with varying overhead density and mode flips
    for (int i = 0; i < 6000; i++) begin
      logic m, o, v;
      lfsr = nx(lfsr);
      m = (i < 2000) ? 1'b0 : (i < 4000) ? 1'b1 : (lfsr[7:5] == 3'd0 ? ~nib_mode : nib_mode);
      o = (i % 3000 < 1000) ? (lfsr[3:2] == 2'b00) : lfsr[2];
      v = lfsr[9:8] != 2'b00;
      step(m, lfsr[0], o, v);
    end
    step(0, 0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_ok, n_chk);
    $finish;
  end
endmodule